// File: doc/BRIEF.md
# DMA Address Window Decoder

This block resolves DMA source and destination addresses against eight programmable memory windows. A window is described by a base register, a size register and one bit in a shared enable register. The base register carries a 64 KiB-aligned base address, an attribute byte and a target interface code. The size register holds the window size minus one, kept at 64 KiB granularity. Each lookup port returns one of two results. On a hit it gives the winning window number, its target code and its attribute byte, passed through unchanged. Otherwise it raises a miss.

Software programs the windows through a simple register port. Writes take effect at the next clock edge, and reads are combinational. The block enforces two programming rules. A window whose base is not a multiple of its size, or whose size mask is not a contiguous run of low ones, is flagged as bad and never matches. A size write that describes less than 64 KiB is refused, and the register keeps its old value. Two lookup ports are provided: index 0 for the source address and index 1 for the destination address. They decode at the same time from the same configuration.

Top module: `dma_window_decoder`

## Requirements
- R1: After reset every window is disabled: the enable register reads 0x0000_00FF, every lookup misses and `bad_win` is zero.
- R2: Register map by byte offset: the base of window n is at 8n, the size of window n is at 8n+4, and the enable register is at 0x40. Address bits [1:0] are ignored. A write changes decode results from the next rising clock edge, and reads are combinational.
- R3: The base register holds the base address in bits [31:16], the attribute in bits [15:8] and the target code in bits [2:0]. Bits [7:3] are not stored and read as zero.
- R4: The size register stores (size-1) bits [31:16]. Bits [15:0] read as zero, and the window mask is {stored bits, 16'hFFFF}.
- R5: A size write whose data is below 0x0000_FFFF (a size under 64 KiB) is refused, and the register keeps its previous value.
- R6: Enable register bit n is active-low: 0 enables window n. Only bits [7:0] are stored, and the upper bits read as zero.
- R7: An address hits window n when n is enabled, not bad, and (addr & ~mask) equals the base. The port then drives `lk_miss`=0 and returns n, the window's target code and its attribute.
- R8: When several windows hit, the lowest-numbered one is reported.
- R9: When no window hits, `lk_miss`=1 and the window, target and attribute outputs are all zero.
- R10: `bad_win[n]` is 1 when the base of window n has a bit set inside its mask, or when its mask is not a contiguous run of low ones. A bad window never hits.
- R11: The two lookup ports decode independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_addr | input | 2x32 | Lookup addresses (0 = source, 1 = destination) |
| lk_miss | output | 2 | Per-port miss flag |
| lk_win | output | 2x3 | Per-port winning window number |
| lk_tgt | output | 2x3 | Per-port target interface code |
| lk_attr | output | 2x8 | Per-port attribute byte |
| bad_win | output | 8 | Per-window illegal configuration flag |

## Verification
The assertions check three things on every cycle. Any reported hit must point at a window that is enabled and legal. A refused size write must leave every size register unchanged. An enable write must land exactly as written. The bench's scenarios are needed for the rest. These are the exact address boundaries of each window, lowest-number priority between overlapping windows, the effect of the disabled, misaligned and non-contiguous windows, the read-back of stored fields, and the one-edge latency of a write before decode changes.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
   // Register kind selected by the register offset.
   typedef enum logic [1:0] {
      RK_NONE,
      RK_BASE,
      RK_SIZE,
      RK_ENABLE
   } reg_kind_e;
endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs
   import dmawin_pkg::*;
#(
   parameter int NUM_WIN = 8,
   parameter int ADDR_W  = 32,
   parameter int GRAN_W  = 16,
   parameter int ATTR_W  = 8,
   parameter int TGT_W   = 3,
   parameter int REG_AW  = 7,
   localparam int WIN_W  = $clog2(NUM_WIN),
   localparam int HI_W   = ADDR_W - GRAN_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               reg_we,
   input  logic [REG_AW-1:0]                  reg_addr,
   input  logic [ADDR_W-1:0]                  reg_wdata,
   output logic [ADDR_W-1:0]                  reg_rdata,
   output logic [NUM_WIN-1:0][HI_W-1:0]       base_q,
   output logic [NUM_WIN-1:0][HI_W-1:0]       size_q,
   output logic [NUM_WIN-1:0][ATTR_W-1:0]     attr_q,
   output logic [NUM_WIN-1:0][TGT_W-1:0]      tgt_q,
   output logic [NUM_WIN-1:0]                 en_n_q
);
   localparam int WORD_W  = REG_AW - 2;
   localparam int EN_WORD = 2 * NUM_WIN;

   logic [WORD_W-1:0] word;
   logic [WIN_W-1:0]  widx;
   reg_kind_e         kind;
   logic              size_small;
   logic              unused_bits;

   assign word        = reg_addr[REG_AW-1:2];
   assign widx        = WIN_W'(word >> 1);
   assign unused_bits = ^{reg_addr[1:0], reg_wdata};

   always_comb begin
      if (int'(word) < EN_WORD)       kind = word[0] ? RK_SIZE : RK_BASE;
      else if (int'(word) == EN_WORD) kind = RK_ENABLE;
      else                            kind = RK_NONE;
   end

   // A size value below one granule minus one means a window under 64 KiB.
   assign size_small = (reg_wdata[ADDR_W-1:GRAN_W] == '0) &&
                       (reg_wdata[GRAN_W-1:0] != '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         attr_q <= '0;
         tgt_q  <= '0;
         en_n_q <= '1;
      end else if (reg_we) begin
         case (kind)
            RK_BASE: begin
               base_q[widx] <= reg_wdata[ADDR_W-1:GRAN_W];
               attr_q[widx] <= reg_wdata[GRAN_W-1 -: ATTR_W];
               tgt_q[widx]  <= reg_wdata[TGT_W-1:0];
            end
            RK_SIZE: begin
               if (!size_small) size_q[widx] <= reg_wdata[ADDR_W-1:GRAN_W];
            end
            RK_ENABLE: en_n_q <= reg_wdata[NUM_WIN-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (kind)
         RK_BASE: begin
            reg_rdata[ADDR_W-1:GRAN_W]    = base_q[widx];
            reg_rdata[GRAN_W-1 -: ATTR_W] = attr_q[widx];
            reg_rdata[TGT_W-1:0]          = tgt_q[widx];
         end
         RK_SIZE:   reg_rdata[ADDR_W-1:GRAN_W] = size_q[widx];
         RK_ENABLE: reg_rdata[NUM_WIN-1:0]     = en_n_q;
         default: ;
      endcase
   end

   // R5
   small_size_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && kind == RK_SIZE && size_small) |=> $stable(size_q));

   // R6
   enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && kind == RK_ENABLE) |=> (en_n_q == $past(reg_wdata[NUM_WIN-1:0])));
endmodule

// File: rtl/dmawin_legal.sv
module dmawin_legal #(
   parameter int NUM_WIN = 8,
   parameter int HI_W    = 16
) (
   input  logic [NUM_WIN-1:0][HI_W-1:0] base_q,
   input  logic [NUM_WIN-1:0][HI_W-1:0] size_q,
   output logic [NUM_WIN-1:0]           bad_win
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic contiguous;
      logic aligned;
      // A contiguous low-ones mask plus one has no bit in common with it.
      assign contiguous = ((size_q[w] & (size_q[w] + HI_W'(1))) == '0);
      assign aligned    = ((base_q[w] & size_q[w]) == '0);
      assign bad_win[w] = !(contiguous && aligned);
   end
endmodule

// File: rtl/dmawin_lookup.sv
module dmawin_lookup #(
   parameter int NUM_WIN = 8,
   parameter int ADDR_W  = 32,
   parameter int GRAN_W  = 16,
   parameter int ATTR_W  = 8,
   parameter int TGT_W   = 3,
   localparam int WIN_W  = $clog2(NUM_WIN),
   localparam int HI_W   = ADDR_W - GRAN_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NUM_WIN-1:0][HI_W-1:0]   base_q,
   input  logic [NUM_WIN-1:0][HI_W-1:0]   size_q,
   input  logic [NUM_WIN-1:0][ATTR_W-1:0] attr_q,
   input  logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_q,
   input  logic [NUM_WIN-1:0]             en_n_q,
   input  logic [NUM_WIN-1:0]             bad_win,
   output logic                           miss,
   output logic [WIN_W-1:0]               win,
   output logic [TGT_W-1:0]               tgt,
   output logic [ATTR_W-1:0]              attr
);
   logic [NUM_WIN-1:0] cand;
   logic               unused_low;

   assign unused_low = ^addr[GRAN_W-1:0];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      assign cand[w] = !en_n_q[w] && !bad_win[w] &&
                       ((addr[ADDR_W-1:GRAN_W] & ~size_q[w]) == base_q[w]);
   end

   // Scan from the top so the lowest-numbered candidate is written last.
   always_comb begin
      miss = 1'b1;
      win  = '0;
      tgt  = '0;
      attr = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (cand[w]) begin
            miss = 1'b0;
            win  = WIN_W'(w);
            tgt  = tgt_q[w];
            attr = attr_q[w];
         end
      end
   end

   // R7
   hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss |-> !en_n_q[win]);

   // R10
   hit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss |-> !bad_win[win]);
endmodule

// File: rtl/dma_window_decoder.sv
module dma_window_decoder #(
   parameter int NUM_WIN = 8,
   parameter int NUM_LK  = 2,
   parameter int ADDR_W  = 32,
   parameter int GRAN_W  = 16,
   parameter int ATTR_W  = 8,
   parameter int TGT_W   = 3,
   parameter int REG_AW  = 7,
   localparam int WIN_W  = $clog2(NUM_WIN)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [REG_AW-1:0]                 reg_addr,
   input  logic [ADDR_W-1:0]                 reg_wdata,
   output logic [ADDR_W-1:0]                 reg_rdata,
   input  logic [NUM_LK-1:0][ADDR_W-1:0]     lk_addr,
   output logic [NUM_LK-1:0]                 lk_miss,
   output logic [NUM_LK-1:0][WIN_W-1:0]      lk_win,
   output logic [NUM_LK-1:0][TGT_W-1:0]      lk_tgt,
   output logic [NUM_LK-1:0][ATTR_W-1:0]     lk_attr,
   output logic [NUM_WIN-1:0]                bad_win
);
   localparam int HI_W = ADDR_W - GRAN_W;

   initial begin
      assert (NUM_WIN >= 2 && NUM_WIN <= ADDR_W) else $error("NUM_WIN out of range");
      assert (ATTR_W + TGT_W <= GRAN_W) else $error("fields overlap in base register");
      assert (GRAN_W < ADDR_W) else $error("granule too large");
      assert ((2 ** REG_AW) > 8 * NUM_WIN) else $error("REG_AW too small for map");
   end

   logic [NUM_WIN-1:0][HI_W-1:0]   base_q;
   logic [NUM_WIN-1:0][HI_W-1:0]   size_q;
   logic [NUM_WIN-1:0][ATTR_W-1:0] attr_q;
   logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_q;
   logic [NUM_WIN-1:0]             en_n_q;

   dmawin_regs #(
      .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
      .ATTR_W(ATTR_W), .TGT_W(TGT_W), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_q(base_q),
      .size_q(size_q), .attr_q(attr_q), .tgt_q(tgt_q), .en_n_q(en_n_q)
   );

   dmawin_legal #(.NUM_WIN(NUM_WIN), .HI_W(HI_W)) u_legal (
      .base_q(base_q), .size_q(size_q), .bad_win(bad_win)
   );

   for (genvar k = 0; k < NUM_LK; k++) begin : g_lk
      dmawin_lookup #(
         .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
         .ATTR_W(ATTR_W), .TGT_W(TGT_W)
      ) u_lookup (
         .clk(clk), .rst_n(rst_n), .addr(lk_addr[k]),
         .base_q(base_q), .size_q(size_q), .attr_q(attr_q), .tgt_q(tgt_q),
         .en_n_q(en_n_q), .bad_win(bad_win),
         .miss(lk_miss[k]), .win(lk_win[k]), .tgt(lk_tgt[k]), .attr(lk_attr[k])
      );
   end
endmodule

// File: tb/dma_window_decoder_test.sv
module dma_window_decoder_test;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [6:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [1:0][31:0] lk_addr = '0;
   logic [1:0]       lk_miss;
   logic [1:0][2:0]  lk_win;
   logic [1:0][2:0]  lk_tgt;
   logic [1:0][7:0]  lk_attr;
   logic [7:0]       bad_win;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dma_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
      .lk_miss(lk_miss), .lk_win(lk_win), .lk_tgt(lk_tgt),
      .lk_attr(lk_attr), .bad_win(bad_win)
   );

   // {addr[31:0], miss, win[2:0], tgt[2:0], attr[7:0]}
   localparam int NV = 14;
   localparam logic [46:0] VEC [0:NV-1] = '{
      {32'h1000_1234, 1'b0, 3'd0, 3'd0, 8'h0E},  // overlaps W1, W0 wins (R8)
      {32'h1000_0000, 1'b0, 3'd0, 3'd0, 8'h0E},
      {32'h10FF_FFFF, 1'b0, 3'd0, 3'd0, 8'h0E},
      {32'h1100_0000, 1'b1, 3'd0, 3'd0, 8'h00},
      {32'h2000_FFFF, 1'b0, 3'd2, 3'd4, 8'hA5},
      {32'h2001_0000, 1'b1, 3'd0, 3'd0, 8'h00},
      {32'h3001_0000, 1'b1, 3'd0, 3'd0, 8'h00},  // misaligned W3 (R10)
      {32'h4000_0000, 1'b1, 3'd0, 3'd0, 8'h00},  // disabled W4
      {32'h5000_8000, 1'b0, 3'd5, 3'd2, 8'h77},
      {32'h5001_0000, 1'b1, 3'd0, 3'd0, 8'h00},  // refused size kept 64K (R5)
      {32'h6000_0000, 1'b1, 3'd0, 3'd0, 8'h00},  // non-contiguous W6 (R10)
      {32'hFFFF_FFFF, 1'b0, 3'd7, 3'd4, 8'hC3},
      {32'h8000_0000, 1'b0, 3'd7, 3'd4, 8'hC3},
      {32'h0000_0000, 1'b1, 3'd0, 3'd0, 8'h00}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic lk_chk(input string req, input int p, input logic [46:0] v);
      chk(req, {lk_miss[p], lk_win[p], lk_tgt[p], lk_attr[p]},
          64'({v[14], v[13:11], v[10:8], v[7:0]}));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 enable reset", 7'h40, 32'h0000_00FF);
      lk_addr[0] = 32'h0000_0000; lk_addr[1] = 32'h1000_0000; #1;
      lk_chk("R1 port0 miss", 0, {32'h0, 1'b1, 14'h0});
      lk_chk("R1 port1 miss", 1, {32'h0, 1'b1, 14'h0});
      chk("R1 bad_win", 64'(bad_win), 64'h0);

      wr(7'h00, 32'h1000_0EF8); wr(7'h04, 32'h00FF_FFFF);
      wr(7'h08, 32'h1000_5A03); wr(7'h0C, 32'h0000_FFFF);
      wr(7'h10, 32'h2000_A5FC); wr(7'h14, 32'h0000_FFFF);
      wr(7'h18, 32'h3001_0000); wr(7'h1C, 32'h0001_FFFF);
      wr(7'h20, 32'h4000_3301); wr(7'h24, 32'h000F_FFFF);
      wr(7'h28, 32'h5000_7702); wr(7'h2C, 32'h0000_1000);
      wr(7'h30, 32'h6000_0000); wr(7'h34, 32'h0005_FFFF);
      wr(7'h38, 32'h8000_C304); wr(7'h3C, 32'h7FFF_FFFF);
      wr(7'h40, 32'hFFFF_FF10);

      rd_chk("R3 base W0 readback", 7'h00, 32'h1000_0E00);
      rd_chk("R3 base W2 readback", 7'h10, 32'h2000_A504);
      rd_chk("R4 size W0 readback", 7'h04, 32'h00FF_0000);
      rd_chk("R4 size W7 readback", 7'h3C, 32'h7FFF_0000);
      rd_chk("R5 refused size W5", 7'h2C, 32'h0000_0000);
      rd_chk("R6 enable readback", 7'h40, 32'h0000_0010);
      rd_chk("R2 low offset bits ignored", 7'h43, 32'h0000_0010);
      rd_chk("R2 base W4 at 0x20", 7'h22, 32'h4000_3301);
      #1;
      chk("R10 bad_win flags", 64'(bad_win), 64'h48);

      // R7 R9 R11 table walk: port0 forward, port1 reversed
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         lk_addr[0] = VEC[i][46:15];
         lk_addr[1] = VEC[NV-1-i][46:15];
         #1;
         lk_chk(VEC[i][14] ? "R9 port0 miss" : "R7 port0 hit", 0, VEC[i]);
         lk_chk(VEC[NV-1-i][14] ? "R11 port1 miss" : "R11 port1 hit", 1, VEC[NV-1-i]);
      end

      // R8: with W0 disabled, the overlapping W1 now wins; checks write latency too (R2)
      lk_addr[0] = 32'h1000_1234;
      lk_addr[1] = 32'h1001_0000;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 7'h40; reg_wdata = 32'h0000_0011;
      #1;
      lk_chk("R2 no change before edge", 0, {32'h0, 1'b0, 3'd0, 3'd0, 8'h0E});
      @(negedge clk);
      reg_we = 1'b0;
      #1;
      lk_chk("R8 W1 wins after W0 off", 0, {32'h0, 1'b0, 3'd1, 3'd3, 8'h5A});
      lk_chk("R8 beyond W1 misses", 1, {32'h0, 1'b1, 14'h0});

      // R10: realign W3 by rewriting its base; it becomes legal and hits
      wr(7'h18, 32'h3002_1102);
      lk_addr[0] = 32'h3003_0004; #1;
      chk("R10 bad_win after realign", 64'(bad_win), 64'h40);
      lk_chk("R10 realigned W3 hits", 0, {32'h0, 1'b0, 3'd3, 3'd2, 8'h11});

      // R5: a size write of exactly one granule minus one is accepted
      wr(7'h2C, 32'h0000_FFFF);
      rd_chk("R5 64K size accepted", 7'h2C, 32'h0000_0000);
      wr(7'h2C, 32'h0000_0FFF);
      wr(7'h24, 32'h0000_8000);
      rd_chk("R5 small write keeps W4 size", 7'h24, 32'h000F_0000);

      summary();
   end
endmodule